// File: doc/BRIEF.md
# Debounced Matrix Keypad Scanner

This block reads a twelve-key switch matrix of four rows and three columns. It pulls one row line low at a time and leaves the others high. It then looks at the active-low column lines for a closed switch. When a row and column meet at a closed key, the block works out a key number from the two indices. It then watches that column for a fixed number of clock cycles to reject contact bounce. Only a closure that stays steady for the whole interval is reported.

A report is a single-cycle strobe together with a key number that stays on the output until the next report. After reporting, the scanner stays on the key's row and waits for the column to return high. The key counts as released only when the column stays high for the same debounce interval. Until then the scanner neither scans nor reports again. Each physical press therefore yields one event, however long the key is held.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and right after it, `rows_n_o` is 4'b1110, `key_valid_o` is 0 and `key_code_o` is 0.
- R2: Exactly one bit of `rows_n_o` is low in every cycle. Bit r low means row r (zero-based) is being driven.
- R3: With no key closed, the driven row steps 0, 1, 2, 3, 0, ... Each row stays driven for SETTLE+1 clock cycles (3 with the default SETTLE of 2).
- R4: A reported key at zero-based row r (bit r of `rows_n_o`) and zero-based column c (bit c of `cols_n_i`) gives `key_code_o` = 3*r + c + 1, so codes run from 1 to 12.
- R5: A key is reported only after its column has read low through the synchronizer for DEBOUNCE consecutive cycles. A closure shorter than that, or one that chatters, gives no report until it is steady.
- R6: A held key gives exactly one report. A new report needs a release that stays high for DEBOUNCE consecutive cycles, and a shorter opening counts as still held.
- R7: `key_valid_o` is high for one cycle per report, and `key_code_o` changes only in a cycle where `key_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cols_n_i | input | 3 | Column lines, active low (0 = a closed key on the driven row) |
| rows_n_o | output | 4 | Row drive, active low, one row at a time |
| key_code_o | output | 4 | Number of the last reported key (1 to 12) |
| key_valid_o | output | 1 | One-cycle strobe marking a new report |

## Verification
The assertions assume the column lines change only through keys on the currently driven row. They also assume at most one key is closed at a time, and that SETTLE is at least 2 so the two-flop synchronizer has caught up before sampling. The stimulus models a single key as a switch between its row and column. It presses one key at a time and applies chatter and short glitches only to that key. No report may be lost or added, so every press the driver queues must be matched by exactly one strobe.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    typedef enum logic [1:0] {
        ST_SCAN      = 2'd0,
        ST_DEB_MAKE  = 2'd1,
        ST_HELD      = 2'd2,
        ST_DEB_BREAK = 2'd3
    } kpd_state_e;

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= 1'b1;
                sync_q[b] <= 1'b1;
            end else begin
                meta_q[b] <= d_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/kpd_encode.sv
module kpd_encode #(
    parameter int ROWS   = 4,
    parameter int COLS   = 3,
    parameter int RW     = 2,
    parameter int CW     = 2,
    parameter int CODE_W = 4
) (
    input  logic [COLS-1:0]   cols_n_i,
    input  logic [RW-1:0]     row_i,
    input  logic [CW-1:0]     col_i,
    output logic              hit_o,
    output logic [CW-1:0]     hit_col_o,
    output logic [CODE_W-1:0] code_o
);
    // lowest-numbered low column wins
    always_comb begin
        hit_o     = 1'b0;
        hit_col_o = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!cols_n_i[c]) begin
                hit_o     = 1'b1;
                hit_col_o = CW'(c);
            end
        end
    end

    // zero-based indices: code = COLS*row + col + 1
    always_comb begin
        code_o = CODE_W'(COLS * int'(row_i) + int'(col_i) + 1);
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kpd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 3,
    parameter int SETTLE   = 2,
    parameter int DEBOUNCE = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [COLS-1:0]                    cols_n_i,
    output logic [ROWS-1:0]                    rows_n_o,
    output logic [$clog2(ROWS*COLS+1)-1:0]     key_code_o,
    output logic                               key_valid_o
);
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW      = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int CODE_W  = $clog2(ROWS*COLS+1);
    localparam int CNT_MAX = (DEBOUNCE > SETTLE) ? DEBOUNCE : SETTLE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        kpd_state_e        st;
        logic [RW-1:0]     row;
        logic [CNT_W-1:0]  cnt;
        logic [CW-1:0]     col;
        logic [CODE_W-1:0] code;
        logic              valid;
    } regs_t;

    regs_t d, q;

    logic [COLS-1:0]   cols_s;
    logic              hit;
    logic [CW-1:0]     hit_col;
    logic [CODE_W-1:0] enc_code;
    logic              held_low;

    kpd_sync #(.W(COLS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cols_n_i),
        .q_o   (cols_s)
    );

    kpd_encode #(
        .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW), .CODE_W(CODE_W)
    ) u_enc (
        .cols_n_i  (cols_s),
        .row_i     (q.row),
        .col_i     (q.col),
        .hit_o     (hit),
        .hit_col_o (hit_col),
        .code_o    (enc_code)
    );

    assign held_low = ~cols_s[q.col];

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.st)
            ST_SCAN: begin
                if (q.cnt == CNT_W'(SETTLE)) begin
                    d.cnt = '0;
                    if (hit) begin
                        d.st  = ST_DEB_MAKE;
                        d.col = hit_col;
                    end else begin
                        d.row = (q.row == RW'(ROWS - 1)) ? '0 : q.row + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DEB_MAKE: begin
                if (!held_low) begin
                    d.st  = ST_SCAN;
                    d.cnt = '0;
                end else if (q.cnt == CNT_W'(DEBOUNCE - 1)) begin
                    d.st    = ST_HELD;
                    d.cnt   = '0;
                    d.valid = 1'b1;
                    d.code  = enc_code;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HELD: begin
                if (!held_low) begin
                    d.st  = ST_DEB_BREAK;
                    d.cnt = '0;
                end
            end
            ST_DEB_BREAK: begin
                if (held_low) begin
                    d.st = ST_HELD;
                end else if (q.cnt == CNT_W'(DEBOUNCE - 1)) begin
                    d.st  = ST_SCAN;
                    d.cnt = '0;
                    d.row = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_SCAN;
            q.row   <= '0;
            q.cnt   <= '0;
            q.col   <= '0;
            q.code  <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rows_n_o    = ~(ROWS'(1) << q.row);
    assign key_code_o  = q.code;
    assign key_valid_o = q.valid;

    assert_one_row_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~rows_n_o) == 1);

    assert_row_settles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN && q.cnt != CNT_W'(SETTLE)) |=> $stable(rows_n_o));

    assert_report_after_make_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> $past(q.st) == ST_DEB_MAKE);

    assert_no_report_while_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HELD) |=> !key_valid_o);

    assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    assert_code_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code_o) |-> key_valid_o);
endmodule

// File: tb/sim_keypad_scanner.sv
module sim_keypad_scanner;
    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int DEB  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cols_n;
    logic [3:0] rows_n;
    logic [3:0] key_code;
    logic       key_valid;

    int  compared = 0;
    int  mismatched = 0;
    int  reports = 0;
    int  expected_total = 0;
    int  last_code = 0;
    bit  after_pulse = 1'b0;
    bit  finished = 1'b0;
    int  exp_q[$];

    // keypad model
    bit pressed = 1'b0;
    int press_r = 0;
    int press_c = 0;

    always #10 clk = ~clk;   // 50 MHz

    always_comb begin
        for (int c = 0; c < COLS; c++)
            cols_n[c] = !(pressed && c == press_c && rows_n[press_r] == 1'b0);
    end

    keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .SETTLE(2), .DEBOUNCE(DEB)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cols_n_i    (cols_n),
        .rows_n_o    (rows_n),
        .key_code_o  (key_code),
        .key_valid_o (key_valid)
    );

    task automatic check(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (after_pulse) begin
                check(key_valid == 1'b0, "R7 strobe width", int'(key_valid), 0);
                check(int'(key_code) == last_code, "R7 code held", int'(key_code), last_code);
                after_pulse = 1'b0;
            end else if (key_valid) begin
                reports++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected report", int'(key_code), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(key_code) == e, "R4 key code", int'(key_code), e);
                end
                last_code   = int'(key_code);
                after_pulse = 1'b1;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one clean press, expected code queued (R4, R6)
    task automatic press(int r, int c, int hold, int rel);
        press_r = r; press_c = c;
        exp_q.push_back(3 * r + c + 1);
        expected_total++;
        pressed = 1'b1;
        idle(hold);
        pressed = 1'b0;
        idle(rel);
    endtask

    task automatic drained(string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(reports == expected_total, req, reports, expected_total);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        check(rows_n == 4'b1110, "R1 rows in reset", int'(rows_n), 14);
        check(key_valid == 1'b0, "R1 valid in reset", int'(key_valid), 0);
        check(key_code == 4'd0, "R1 code in reset", int'(key_code), 0);
        rst_n = 1'b1;
        idle(1);
        check(rows_n == 4'b1110, "R1 rows after reset", int'(rows_n), 14);

        // R3: scan order and dwell, aligned to the first step to row 1
        while (rows_n != 4'b1101) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            int er;
            er = (1 + i / 3) % 4;
            check(rows_n == ~(4'b0001 << er), "R3 scan order", int'(rows_n), int'(~(4'b0001 << er) & 4'hF));
            check($countones(~rows_n) == 1, "R2 one row", $countones(~rows_n), 1);
            idle(1);
        end

        // R4: every key once
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                press(r, c, 60, 40);
        drained("R4 all keys");

        // R5: short glitch gives no report
        press_r = 1; press_c = 1;
        pressed = 1'b1; idle(3); pressed = 1'b0;
        idle(60);
        drained("R5 glitch ignored");

        // R5: chatter then steady closure gives exactly one report (code 7)
        press_r = 2; press_c = 0;
        for (int k = 0; k < 8; k++) begin
            pressed = ~pressed;
            idle(2);
        end
        exp_q.push_back(7); expected_total++;
        pressed = 1'b1; idle(60); pressed = 1'b0; idle(40);
        drained("R5 chatter");

        // R6: long hold gives one report (code 12)
        press(3, 2, 300, 40);
        drained("R6 long hold");

        // R6: short opening while held is not a break (code 2 once)
        press_r = 0; press_c = 1;
        exp_q.push_back(2); expected_total++;
        pressed = 1'b1; idle(60);
        pressed = 1'b0; idle(3);
        pressed = 1'b1; idle(60);
        pressed = 1'b0; idle(40);
        drained("R6 release bounce");

        // R6: after a confirmed break the same key reports again
        press(0, 1, 60, 40);
        drained("R6 re-press");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule